// File: doc/BRIEF.md
# Multi-Mode Prescaled Down-Counter Timer

This block is a two-stage down counter: an 8-bit prescaler whose underflows clock an 8-bit timer. Each stage holds a reload value in its own latch and divides its input pulses by the latch value plus one. A 2-bit mode input selects what drives the prescaler. Interval mode and pulse-output mode count an internal clock tick. Event mode counts edges on an external pin. Width mode counts the internal tick only while the pin holds a chosen level. In pulse-output mode the timer also toggles a pin output on every underflow.

A single polarity input sets how each mode behaves. It gives the starting level of the pulse output, the edge that event mode counts, and the pin level that enables counting in width mode. A stop input freezes both stages in every mode. The block signals each timer underflow with a one-clock interrupt request pulse. It also reports every active pin edge as a separate pulse, so the pin can raise its own interrupt.

Software is expected to pick the count source first and load the latches after that. A latch write made while the block is stopped also loads the counter. A latch write made while the block runs only takes effect at the next reload.

Top module: `ptimer_top`

## Requirements
- R1: Each stage counts down by one per input pulse. With prescaler latch P and timer latch T, interval mode underflows the timer once every (P+1)*(T+1) source ticks.
- R2: A pulse that arrives while a stage holds 0 is an underflow. It reloads that stage from its latch. Every timer underflow produces `irq_o` high for exactly one clock, one clock after the underflow.
- R3: `src_sel_i`=0 selects one source tick every 2 clocks. `src_sel_i`=1 selects one tick every 16 clocks.
- R4: When `mode_i`=01 (pulse output), `pin_o` inverts on each timer underflow. In any other mode `pin_o` rests at the inverse of `edge_sel_i`, so pulse output starts high when `edge_sel_i`=0 and low when it is 1. After reset `pin_o` is 1.
- R5: When `mode_i`=10 (event), the prescaler counts rising pin edges when `edge_sel_i`=0 and falling edges when it is 1. The opposite edge is ignored.
- R6: When `mode_i`=11 (width), source ticks are counted only while the synchronized pin is high (`edge_sel_i`=0) or low (`edge_sel_i`=1).
- R7: While `stop_i`=1 neither stage changes on pulses in any mode, and no underflow occurs. The count position is kept.
- R8: A latch write while `stop_i`=1 also loads the counter. A write while running changes only the latch, which is used at the next reload.
- R9: If a latch write lands in the same clock as that stage's reload, the stage reloads the newly written value.
- R10: `pin_i` passes through two synchronizer flops. `pin_evt_o` pulses for one clock on each active edge, as chosen by `edge_sel_i`, in every mode.
- R11: After reset both counters and both latches are 0, and `irq_o` and `pin_evt_o` are 0. `mode_i` encoding: 00 interval, 01 pulse output, 10 event, 11 width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_wr_i | input | 1 | Write strobe for the prescaler latch |
| tmr_wr_i | input | 1 | Write strobe for the timer latch |
| wdata_i | input | 8 | Write data for either latch |
| mode_i | input | 2 | Operating mode (00 interval, 01 pulse, 10 event, 11 width) |
| edge_sel_i | input | 1 | Polarity: start level, counted edge or gating level |
| stop_i | input | 1 | Freezes both stages when 1 |
| src_sel_i | input | 1 | Source tick: 0 = clk/2, 1 = clk/16 |
| pin_i | input | 1 | External pin (asynchronous) |
| pin_o | output | 1 | Pulse output level |
| irq_o | output | 1 | One-clock pulse per timer underflow |
| pin_evt_o | output | 1 | One-clock pulse per active pin edge |

## Verification
The two functions that can meet in one cycle are a running latch write and the stage reload caused by an underflow. The bench provokes the collision in event mode with a prescaler latch of 0 and a timer sitting at 0. It drives a rising pin edge, counts the two synchronizer flops, and places the timer latch write on the exact clock at which that edge underflows the timer. The outcome is judged from the number of edges to the following interrupt. Four edges show that the written value was reloaded. One edge would show that the stale latch value won.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  typedef enum logic [1:0] {
    MODE_INTERVAL = 2'b00,
    MODE_PULSE    = 2'b01,
    MODE_EVENT    = 2'b10,
    MODE_WIDTH    = 2'b11
  } tmr_mode_e;

  // Edge chosen by the polarity bit: 0 -> rising, 1 -> falling.
  function automatic logic pick_edge(input logic rise, input logic fall,
                                     input logic pol);
    return pol ? fall : rise;
  endfunction

  // Width gate: counting enabled while the level differs from the polarity bit.
  function automatic logic level_open(input logic lvl, input logic pol);
    return lvl ^ pol;
  endfunction

endpackage

// File: rtl/ptmr_srcdiv.sv
module ptmr_srcdiv #(
  parameter int SLOW_DIV = 16,
  parameter int FAST_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_slow_i,
  output logic tick_o
);
  localparam int CW = $clog2(SLOW_DIV);
  localparam logic [CW-1:0] SLOW_M = CW'(SLOW_DIV - 1);
  localparam logic [CW-1:0] FAST_M = CW'(FAST_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = sel_slow_i ? (cnt_q == SLOW_M) : ((cnt_q & FAST_M) == FAST_M);

  // R3: both dividers are at least 2, so ticks never come back to back
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && $stable(sel_slow_i)) |=> !tick_o);

endmodule

// File: rtl/ptmr_pinsync.sv
module ptmr_pinsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sq;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sq[g] <= 1'b0;
      else if (g == 0) sq[g] <= pin_i;
      else             sq[g] <= sq[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_o;
  end

  assign lvl_o  = sq[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;

  // R10: an edge pulse lasts one clock
  a_r10_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
  a_r10_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/ptmr_stage.sv
module ptmr_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         stop_i,
  input  logic         pulse_i,
  output logic         uf_o
);
  logic [W-1:0] latch_q, cnt_q, reload_val;
  logic         step;

  function automatic logic [W-1:0] next_down(input logic [W-1:0] cur,
                                             input logic [W-1:0] rl);
    return (cur == '0) ? rl : cur - W'(1);
  endfunction

  assign step       = pulse_i & ~stop_i;
  assign reload_val = wr_i ? wdata_i : latch_q;   // R9: fresh write wins
  assign uf_o       = step & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (wr_i) latch_q <= wdata_i;
      if (wr_i && stop_i) cnt_q <= wdata_i;
      else if (step)      cnt_q <= next_down(cnt_q, reload_val);
    end
  end

  // R1: plain decrement
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q != '0) |=> cnt_q == $past(cnt_q) - W'(1));
  // R2 / R9: reload at underflow takes the written value when one arrives
  a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q == '0) |=> cnt_q == ($past(wr_i) ? $past(wdata_i) : $past(latch_q)));
  // R7: stopped stage holds its count
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !wr_i) |=> $stable(cnt_q));
  // R8: write while stopped loads the counter
  a_r8_stopped_load: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && wr_i) |=> cnt_q == $past(wdata_i));

endmodule

// File: rtl/ptimer_top.sv
module ptimer_top #(
  parameter int W        = 8,
  parameter int SLOW_DIV = 16,
  parameter int FAST_DIV = 2,
  parameter int SYNC_STG = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pre_wr_i,
  input  logic         tmr_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [1:0]   mode_i,
  input  logic         edge_sel_i,
  input  logic         stop_i,
  input  logic         src_sel_i,
  input  logic         pin_i,
  output logic         pin_o,
  output logic         irq_o,
  output logic         pin_evt_o
);
  import ptmr_pkg::*;

  tmr_mode_e mode;
  logic src_tick, lvl, rise, fall, act_edge;
  logic pre_in, pre_uf, tmr_uf;
  logic pin_q, irq_q;

  assign mode = tmr_mode_e'(mode_i);

  ptmr_srcdiv #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_src (
    .clk(clk), .rst_n(rst_n), .sel_slow_i(src_sel_i), .tick_o(src_tick));

  ptmr_pinsync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall));

  assign act_edge = pick_edge(rise, fall, edge_sel_i);

  always_comb begin
    unique case (mode)
      MODE_EVENT: pre_in = act_edge;
      MODE_WIDTH: pre_in = src_tick & level_open(lvl, edge_sel_i);
      default:    pre_in = src_tick;
    endcase
  end

  ptmr_stage #(.W(W)) u_pre (
    .clk(clk), .rst_n(rst_n), .wr_i(pre_wr_i), .wdata_i(wdata_i),
    .stop_i(stop_i), .pulse_i(pre_in), .uf_o(pre_uf));

  ptmr_stage #(.W(W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .wr_i(tmr_wr_i), .wdata_i(wdata_i),
    .stop_i(stop_i), .pulse_i(pre_uf), .uf_o(tmr_uf));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b1;
      irq_q <= 1'b0;
    end else begin
      irq_q <= tmr_uf;
      if (mode != MODE_PULSE) pin_q <= ~edge_sel_i;
      else if (tmr_uf)        pin_q <= ~pin_q;
    end
  end

  assign pin_o     = pin_q;
  assign irq_o     = irq_q;
  assign pin_evt_o = act_edge;

  // R2: one request pulse per underflow, one clock later
  a_r2_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_uf |=> irq_o);
  a_r2_irq_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_uf |=> !irq_o);
  // R4: toggle on underflow in pulse mode, idle level elsewhere
  a_r4_pin_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PULSE && tmr_uf) |=> pin_o != $past(pin_o));
  a_r4_pin_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_PULSE) |=> pin_o == !$past(edge_sel_i));
  // R5: event mode advances only on the selected edge
  a_r5_event_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_EVENT && !act_edge) |-> !pre_uf);
  // R6: width mode blocked at the inactive level
  a_r6_width_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WIDTH && lvl == edge_sel_i) |-> !pre_uf);
  // R7: no underflow while stopped
  a_r7_no_uf: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |-> !tmr_uf && !pre_uf);

endmodule

// File: tb/ptimer_top_tb.sv
module ptimer_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pre_wr = 0, tmr_wr = 0, edge_sel = 0, stop = 1, src_sel = 0, pin = 0;
  logic [7:0] wdata = 0;
  logic [1:0] mode = 2'b00;
  logic pin_o, irq_o, pin_evt_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptimer_top u_dut (
    .clk(clk), .rst_n(rst_n), .pre_wr_i(pre_wr), .tmr_wr_i(tmr_wr),
    .wdata_i(wdata), .mode_i(mode), .edge_sel_i(edge_sel), .stop_i(stop),
    .src_sel_i(src_sel), .pin_i(pin), .pin_o(pin_o), .irq_o(irq_o),
    .pin_evt_o(pin_evt_o));

  typedef struct { int val; bit by_edges; string tag; } exp_t;
  exp_t q[$];

  int vectors = 0, miscompares = 0;
  int cyc = 0, base_c = 0, base_e = 0, edges_sent = 0, evt_seen = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int v, input bit e, input string tag);
    exp_t it;
    it.val = v; it.by_edges = e; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: pops one expectation per interrupt pulse
  always @(negedge clk) begin
    cyc++;
    if (pin_evt_o) evt_seen++;
    if (irq_o && rst_n) begin
      if (q.size() == 0) begin
        check(0, "unexpected irq (R7/R6)", 1, 0);
      end else begin
        exp_t it;
        int got;
        it  = q.pop_front();
        got = it.by_edges ? (edges_sent - base_e) : (cyc - base_c);
        if (it.val >= 0) check(got == it.val, it.tag, got, it.val);
      end
      base_c = cyc;
      base_e = edges_sent;
    end
  end

  task automatic mark(); base_e = edges_sent; endtask

  task automatic drain(input int limit);
    int n = 0;
    while (q.size() != 0 && n < limit) begin @(negedge clk); n++; end
    if (q.size() != 0) begin
      check(0, {"timeout waiting for irq ", q[0].tag}, q.size(), 0);
      q.delete();
    end
  endtask

  task automatic wr_pre(input logic [7:0] v);
    @(negedge clk); pre_wr = 1; wdata = v; @(negedge clk); pre_wr = 0;
  endtask
  task automatic wr_tmr(input logic [7:0] v);
    @(negedge clk); tmr_wr = 1; wdata = v; @(negedge clk); tmr_wr = 0;
  endtask

  task automatic pin_pulse();
    @(negedge clk); pin = 1; if (!edge_sel) edges_sent++;
    repeat (5) @(negedge clk);
    pin = 0; if (edge_sel) edges_sent++;
    repeat (5) @(negedge clk);
  endtask

  task automatic wait_irq();
    int n = 0;
    @(negedge clk);
    while (!irq_o && n < 400) begin @(negedge clk); n++; end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int ev0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(irq_o == 0, "R11 irq_o at reset", irq_o, 0);
    check(pin_o == 1, "R11 pin_o at reset", pin_o, 1);
    check(pin_evt_o == 0, "R11 pin_evt_o at reset", pin_evt_o, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(irq_o == 0, "R11 irq_o after release", irq_o, 0);

    // R1: interval mode, clk/2, P=1 T=2 -> 2*3*2 = 12 clocks
    mode = 2'b00; src_sel = 0;
    wr_pre(8'd1); wr_tmr(8'd2);
    push(-1, 0, "R1 first"); push(12, 0, "R1 interval"); push(12, 0, "R1 interval");
    push(12, 0, "R1 interval");
    @(negedge clk); stop = 0;
    drain(400); stop = 1;

    // R3: clk/16, P=0 T=3 -> 4*16 = 64 clocks
    src_sel = 1;
    wr_pre(8'd0); wr_tmr(8'd3);
    push(-1, 0, "R3 first"); push(64, 0, "R3 slow source"); push(64, 0, "R3 slow source");
    @(negedge clk); stop = 0;
    drain(1000); stop = 1; src_sel = 0;

    // R4: idle levels and toggling
    @(negedge clk); edge_sel = 1; repeat (2) @(negedge clk);
    check(pin_o == 0, "R4 idle level edge_sel=1", pin_o, 0);
    edge_sel = 0; repeat (2) @(negedge clk);
    check(pin_o == 1, "R4 idle level edge_sel=0", pin_o, 1);
    mode = 2'b01;
    wr_pre(8'd0); wr_tmr(8'd4);
    push(-1, 0, "R4 first"); push(10, 0, "R4 pulse period"); push(10, 0, "R4 pulse period");
    @(negedge clk); stop = 0;
    wait_irq(); check(pin_o == 0, "R4 toggle 1", pin_o, 0);
    wait_irq(); check(pin_o == 1, "R4 toggle 2", pin_o, 1);
    wait_irq(); check(pin_o == 0, "R4 toggle 3", pin_o, 0);
    stop = 1;
    drain(50);

    // R5 / R10: event mode, rising edges, P=1 T=1 -> 4 edges
    mode = 2'b10; edge_sel = 0;
    wr_pre(8'd1); wr_tmr(8'd1);
    @(negedge clk); stop = 0; mark(); ev0 = evt_seen;
    push(4, 1, "R5 rising edges"); push(4, 1, "R5 rising edges");
    for (int i = 0; i < 8; i++) pin_pulse();
    drain(100);
    check(evt_seen - ev0 == 8, "R10 rising event pulses", evt_seen - ev0, 8);

    // R5 / R10: falling edges
    @(negedge clk); stop = 1; edge_sel = 1;
    wr_pre(8'd1); wr_tmr(8'd1);
    @(negedge clk); stop = 0; mark(); ev0 = evt_seen;
    push(4, 1, "R5 falling edges"); push(4, 1, "R5 falling edges");
    for (int i = 0; i < 8; i++) pin_pulse();
    drain(100);
    check(evt_seen - ev0 == 8, "R10 falling event pulses", evt_seen - ev0, 8);
    @(negedge clk); stop = 1; edge_sel = 0;

    // R6: width mode, count while high; P=0 T=3 clk/2 -> 8 clocks
    mode = 2'b11; pin = 0;
    wr_pre(8'd0); wr_tmr(8'd3);
    @(negedge clk); stop = 0;
    repeat (100) @(negedge clk);   // pin low: any irq is a miscompare
    push(-1, 0, "R6 first"); push(8, 0, "R6 high gate"); push(8, 0, "R6 high gate");
    pin = 1;
    drain(300);
    pin = 0; repeat (10) @(negedge clk);
    edge_sel = 1;                  // now count while low
    push(-1, 0, "R6 first low"); push(8, 0, "R6 low gate");
    drain(300);
    pin = 1; repeat (60) @(negedge clk);
    stop = 1; edge_sel = 0; pin = 0; repeat (4) @(negedge clk);

    // R7: stop in every mode keeps the count position
    mode = 2'b10;
    wr_pre(8'd0); wr_tmr(8'd2);
    for (int m = 0; m < 4; m++) begin
      @(negedge clk); mode = 2'(m);
      pin_pulse(); pin_pulse();
      repeat (20) @(negedge clk);
    end
    @(negedge clk); mode = 2'b10; stop = 0; mark();
    push(3, 1, "R7 count held while stopped");
    for (int i = 0; i < 3; i++) pin_pulse();
    drain(100);

    // R8: running write changes only the latch
    @(negedge clk); stop = 1;
    wr_pre(8'd0); wr_tmr(8'd5);
    @(negedge clk); stop = 0; mark();
    push(6, 1, "R8 running write not loaded"); push(2, 1, "R8 new latch at reload");
    pin_pulse(); pin_pulse();
    wr_tmr(8'd1);
    for (int i = 0; i < 6; i++) pin_pulse();
    drain(100);

    // R9: latch write in the reload cycle
    @(negedge clk); stop = 1;
    wr_pre(8'd0); wr_tmr(8'd0);
    @(negedge clk); stop = 0; mark();
    push(1, 1, "R9 underflow at collision"); push(4, 1, "R9 reload takes new value");
    @(negedge clk); pin = 1; edges_sent++;
    @(posedge clk); @(posedge clk);
    @(negedge clk); tmr_wr = 1; wdata = 8'd3;
    @(negedge clk); tmr_wr = 0;
    repeat (4) @(negedge clk); pin = 0;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 4; i++) pin_pulse();
    drain(100);
    @(negedge clk); stop = 1;
    repeat (5) @(negedge clk);

    done = 1;
    summary();
    $finish;
  end
endmodule